// File: doc/BRIEF.md
# Registered Multiply-Accumulate Unit with Field Preload

This block multiplies two 16-bit operands and keeps a 35-bit running result. The result is held in three output registers: a 3-bit guard field, a 16-bit upper field and a 16-bit lower field. Each operand has its own capture register. The two's-complement flag is captured with the operands, so a product can be formed from a freshly loaded X and a Y that was held from an earlier load. A separate result strobe then folds the product into the result registers.

The controls are sampled with the result strobe. They choose a plain product, an addition to the running result or a subtraction from it, and whether to round. Rounding adds half a unit of the upper field and leaves the lower field as it was. In preload mode the outputs are disabled, and each field's enable line becomes a write strobe for that field. This lets a host seed the accumulator with any 35-bit value. The lower field shares the Y pin group, so its preload data arrives on the Y input and its output enable must never overlap with driving Y.

Top module: `mac16_unit`

## Requirements
- R1: A synchronous active-high reset clears the operand registers, the signedness flag and all three result fields to zero.
- R2: `x_ce` loads `x_in` and `y_ce` loads `y_in` into the operand registers. Either strobe also loads `tc_in`. An operand whose strobe is low keeps its old value and is used unchanged by later products.
- R3: With `acc_in` low and the captured flag clear, a result strobe stores the 32-bit unsigned product with the guard field zero. `sub_in` has no effect in this mode.
- R4: With `acc_in` low and the captured flag set, a result strobe stores the signed product, sign-extended through the guard field.
- R5: With `acc_in` high and `sub_in` low, the new result is the previous 35-bit result plus the extended product, modulo 2^35.
- R6: With `acc_in` and `sub_in` both high, the new result is the previous result minus the extended product, modulo 2^35.
- R7: With `rnd_in` high, the guard and upper fields take bits 34..16 of (sum + 2^15), and the lower field takes bits 15..0 of the unrounded sum.
- R8: While `p_ce` and `preload` are both low, all three result fields hold their values.
- R9: Each field's output-enable equals its enable input while `preload` is low, and is forced low while `preload` is high.
- R10: While `preload` is high, a high `xt_en` loads `xt_din`, a high `ms_en` loads `ms_din` and a high `ls_en` loads `y_in` into the matching field. Fields with a low enable hold. `p_ce` is ignored.
- R11: An accumulation after a preload uses the preloaded 35-bit value as the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | X operand |
| x_ce | input | 1 | X capture strobe |
| y_in | input | 16 | Y operand, also lower-field preload data |
| y_ce | input | 1 | Y capture strobe |
| tc_in | input | 1 | Two's-complement flag, captured with either operand |
| p_ce | input | 1 | Result register update strobe |
| acc_in | input | 1 | Accumulate instead of plain multiply |
| sub_in | input | 1 | Subtract when accumulating |
| rnd_in | input | 1 | Round into the upper fields |
| preload | input | 1 | Preload mode select |
| xt_en | input | 1 | Guard field enable / preload strobe |
| ms_en | input | 1 | Upper field enable / preload strobe |
| ls_en | input | 1 | Lower field enable / preload strobe |
| xt_din | input | 3 | Guard field preload data |
| ms_din | input | 16 | Upper field preload data |
| xt_dout | output | 3 | Guard field value |
| xt_oe | output | 1 | Guard field output enable |
| ms_dout | output | 16 | Upper field value |
| ms_oe | output | 1 | Upper field output enable |
| ls_dout | output | 16 | Lower field value |
| ls_oe | output | 1 | Lower field output enable |

## Verification
The hardest state to reach from the ports is an accumulation whose previous value has nonzero guard bits. A preload followed by an add or subtract also has to be checked. Reaching a nonzero guard field through products alone needs several maximum-magnitude products in a row. The vector table therefore chains unsigned full-scale products into the guard bits, and a directed test preloads all three fields with arbitrary data before it accumulates. A second directed test loads only X while Y is held, which shows that each operand register keeps its value on its own.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
  // Controls sampled together with the result strobe
  typedef struct packed {
    logic acc;
    logic sub;
    logic rnd;
  } mac_ctl_t;
endpackage

// File: rtl/mac16_opreg.sv
module mac16_opreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/mac16_mult.sv
module mac16_mult #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input  logic [OP_W-1:0]           a,
  input  logic [OP_W-1:0]           b,
  input  logic                      tc,
  output logic [2*OP_W+GUARD_W-1:0] prod_ext
);
  localparam int PW = 2 * OP_W;

  logic [PW-1:0] s_prod;
  logic [PW-1:0] u_prod;

  always_comb begin
    s_prod = $signed({{OP_W{a[OP_W-1]}}, a}) * $signed({{OP_W{b[OP_W-1]}}, b});
    u_prod = {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
    if (tc) prod_ext = {{GUARD_W{s_prod[PW-1]}}, s_prod};
    else    prod_ext = {{GUARD_W{1'b0}}, u_prod};
  end
endmodule

// File: rtl/mac16_accum.sv
module mac16_accum
  import mac16_pkg::*;
#(
  parameter int ACC_W = 35,
  parameter int LS_W  = 16
) (
  input  logic [ACC_W-1:0] prev,
  input  logic [ACC_W-1:0] prod,
  input  mac_ctl_t         ctl,
  output logic [ACC_W-1:0] next
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (LS_W - 1);

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rounded;

  always_comb begin
    if (!ctl.acc)     sum = prod;
    else if (ctl.sub) sum = prev - prod;
    else              sum = prev + prod;
    rounded = sum + HALF;
    if (ctl.rnd) next = {rounded[ACC_W-1:LS_W], sum[LS_W-1:0]};
    else         next = sum;
  end
endmodule

// File: rtl/mac16_resreg.sv
module mac16_resreg #(
  parameter int GUARD_W = 3,
  parameter int F_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic                       preload,
  input  logic                       ld_xt,
  input  logic                       ld_ms,
  input  logic                       ld_ls,
  input  logic [GUARD_W+2*F_W-1:0]   next,
  input  logic [GUARD_W-1:0]         xt_d,
  input  logic [F_W-1:0]             ms_d,
  input  logic [F_W-1:0]             ls_d,
  output logic [GUARD_W-1:0]         xt_q,
  output logic [F_W-1:0]             ms_q,
  output logic [F_W-1:0]             ls_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xt_q <= '0;
      ms_q <= '0;
      ls_q <= '0;
    end else if (preload) begin
      if (ld_xt) xt_q <= xt_d;
      if (ld_ms) ms_q <= ms_d;
      if (ld_ls) ls_q <= ls_d;
    end else if (ce) begin
      {xt_q, ms_q, ls_q} <= next;
    end
  end
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
  import mac16_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    x_in,
  input  logic               x_ce,
  input  logic [OP_W-1:0]    y_in,
  input  logic               y_ce,
  input  logic               tc_in,
  input  logic               p_ce,
  input  logic               acc_in,
  input  logic               sub_in,
  input  logic               rnd_in,
  input  logic               preload,
  input  logic               xt_en,
  input  logic               ms_en,
  input  logic               ls_en,
  input  logic [GUARD_W-1:0] xt_din,
  input  logic [OP_W-1:0]    ms_din,
  output logic [GUARD_W-1:0] xt_dout,
  output logic               xt_oe,
  output logic [OP_W-1:0]    ms_dout,
  output logic               ms_oe,
  output logic [OP_W-1:0]    ls_dout,
  output logic               ls_oe
);
  localparam int ACC_W = 2 * OP_W + GUARD_W;

  logic [OP_W-1:0]  x_q;
  logic [OP_W-1:0]  y_q;
  logic             tc_q;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] next_res;
  mac_ctl_t         ctl;

  mac16_opreg #(.W(OP_W)) u_xreg (
    .clk(clk), .rst(rst), .ce(x_ce), .d(x_in), .q(x_q)
  );

  mac16_opreg #(.W(OP_W)) u_yreg (
    .clk(clk), .rst(rst), .ce(y_ce), .d(y_in), .q(y_q)
  );

  mac16_opreg #(.W(1)) u_tcreg (
    .clk(clk), .rst(rst), .ce(x_ce | y_ce), .d(tc_in), .q(tc_q)
  );

  mac16_mult #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_mult (
    .a(x_q), .b(y_q), .tc(tc_q), .prod_ext(prod_ext)
  );

  assign ctl = '{acc: acc_in, sub: sub_in, rnd: rnd_in};

  mac16_accum #(.ACC_W(ACC_W), .LS_W(OP_W)) u_accum (
    .prev({xt_dout, ms_dout, ls_dout}), .prod(prod_ext), .ctl(ctl), .next(next_res)
  );

  mac16_resreg #(.GUARD_W(GUARD_W), .F_W(OP_W)) u_res (
    .clk(clk), .rst(rst), .ce(p_ce), .preload(preload),
    .ld_xt(xt_en), .ld_ms(ms_en), .ld_ls(ls_en),
    .next(next_res), .xt_d(xt_din), .ms_d(ms_din), .ls_d(y_in),
    .xt_q(xt_dout), .ms_q(ms_dout), .ls_q(ls_dout)
  );

  assign xt_oe = xt_en & ~preload;
  assign ms_oe = ms_en & ~preload;
  assign ls_oe = ls_en & ~preload;
endmodule

// File: rtl/mac16_unit_chk.sv
module mac16_unit_chk #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               p_ce,
  input logic               acc_in,
  input logic               rnd_in,
  input logic               preload,
  input logic               ms_en,
  input logic               ls_en,
  input logic               tc_q,
  input logic [OP_W-1:0]    ms_din,
  input logic [GUARD_W-1:0] xt_dout,
  input logic [OP_W-1:0]    ms_dout,
  input logic [OP_W-1:0]    ls_dout,
  input logic               xt_oe,
  input logic               ms_oe,
  input logic               ls_oe
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (xt_dout == '0 && ms_dout == '0 && ls_dout == '0));

  // R3
  unsigned_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (p_ce && !preload && !acc_in && !rnd_in && !tc_q) |=> (xt_dout == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!p_ce && !preload) |=> $stable({xt_dout, ms_dout, ls_dout}));

  // R9
  preload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    preload |-> !(xt_oe || ms_oe || ls_oe));

  // R10
  preload_ms_chk: assert property (@(posedge clk) disable iff (rst)
    (preload && ms_en) |=> (ms_dout == $past(ms_din)));

  // R10
  preload_ls_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (preload && !ls_en) |=> $stable(ls_dout));
endmodule

bind mac16_unit mac16_unit_chk #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_chk (
  .clk(clk), .rst(rst), .p_ce(p_ce), .acc_in(acc_in), .rnd_in(rnd_in),
  .preload(preload), .ms_en(ms_en), .ls_en(ls_en), .tc_q(tc_q),
  .ms_din(ms_din), .xt_dout(xt_dout), .ms_dout(ms_dout), .ls_dout(ls_dout),
  .xt_oe(xt_oe), .ms_oe(ms_oe), .ls_oe(ls_oe)
);

// File: tb/mac16_unit_bench.sv
module mac16_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] x_in, y_in, ms_din;
  logic        x_ce, y_ce, tc_in, p_ce, acc_in, sub_in, rnd_in;
  logic        preload, xt_en, ms_en, ls_en;
  logic [2:0]  xt_din;
  logic [2:0]  xt_dout;
  logic [15:0] ms_dout, ls_dout;
  logic        xt_oe, ms_oe, ls_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [34:0] model;

  always #2 clk = ~clk;

  mac16_unit u_mac16_unit (
    .clk(clk), .rst(rst), .x_in(x_in), .x_ce(x_ce), .y_in(y_in), .y_ce(y_ce),
    .tc_in(tc_in), .p_ce(p_ce), .acc_in(acc_in), .sub_in(sub_in), .rnd_in(rnd_in),
    .preload(preload), .xt_en(xt_en), .ms_en(ms_en), .ls_en(ls_en),
    .xt_din(xt_din), .ms_din(ms_din), .xt_dout(xt_dout), .xt_oe(xt_oe),
    .ms_dout(ms_dout), .ms_oe(ms_oe), .ls_dout(ls_dout), .ls_oe(ls_oe)
  );

  // Stimulus: {tc, acc, sub, rnd, x[15:0], y[15:0]}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    36'h0_FFFF_FFFF,  // unsigned full scale
    36'h4_FFFF_FFFF,  // accumulate into guard bits
    36'h4_FFFF_FFFF,
    36'h2_1234_5678,  // sub without acc: plain multiply (R6 ignored case)
    36'h8_8000_8000,  // signed most negative squared
    36'h8_FFFF_0003,  // signed negative product
    36'hC_7FFF_8000,  // signed accumulate
    36'hE_7FFF_7FFF,  // signed subtract
    36'h1_0001_8000,  // rounding carries into upper field
    36'h9_FFFF_8000,  // signed rounding
    36'h5_0001_7FFF,  // accumulate with rounding
    36'h6_0002_0003   // unsigned subtract
  };

  function automatic logic [34:0] step(logic [34:0] prev, logic [3:0] c,
                                       logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    logic [34:0] e, s, r;
    if (c[3]) begin
      p = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
      e = {{3{p[31]}}, p};
    end else begin
      p = {16'h0, a} * {16'h0, b};
      e = {3'b000, p};
    end
    if (!c[2])     s = e;
    else if (c[1]) s = prev - e;
    else           s = prev + e;
    r = s + 35'h8000;
    return c[0] ? {r[34:16], s[15:0]} : s;
  endfunction

  task automatic check(string req, logic [34:0] act, logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [3:0] c, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    x_in = a; y_in = b; tc_in = c[3]; x_ce = 1; y_ce = 1;
    @(negedge clk);
    x_ce = 0; y_ce = 0; p_ce = 1; acc_in = c[2]; sub_in = c[1]; rnd_in = c[0];
    @(negedge clk);
    p_ce = 0;
    model = step(model, c, a, b);
  endtask

  function automatic string tag_of(logic [3:0] c);
    if (c[0]) return "R7";
    if (c[2] && c[1]) return "R6";
    if (c[2]) return "R5";
    if (c[3]) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; x_in = 0; y_in = 0; ms_din = 0; xt_din = 0;
    x_ce = 0; y_ce = 0; tc_in = 0; p_ce = 0; acc_in = 0; sub_in = 0; rnd_in = 0;
    preload = 0; xt_en = 0; ms_en = 0; ls_en = 0;
    model = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1", {xt_dout, ms_dout, ls_dout}, 35'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);
      check(tag_of(VEC[i][35:32]), {xt_dout, ms_dout, ls_dout}, model);
    end

    // R2: load X only, Y held from earlier load
    run_op(4'h0, 16'd5, 16'd7);
    @(negedge clk);
    x_in = 16'd9; y_in = 16'hFFFF; x_ce = 1; tc_in = 0;
    @(negedge clk);
    x_ce = 0; p_ce = 1; acc_in = 0; sub_in = 0; rnd_in = 0;
    @(negedge clk);
    p_ce = 0;
    check("R2", {xt_dout, ms_dout, ls_dout}, 35'd63);
    // R2: inputs change without strobes; product unchanged
    x_in = 16'h4444; y_in = 16'h5555;
    @(negedge clk);
    p_ce = 1; acc_in = 1;
    @(negedge clk);
    p_ce = 0; acc_in = 0;
    check("R2", {xt_dout, ms_dout, ls_dout}, 35'd126);
    model = 35'd126;

    // R8: idle with busy inputs holds the result
    x_in = 16'h1111; y_in = 16'h2222; acc_in = 1; rnd_in = 1; ms_din = 16'hDEAD;
    repeat (4) @(negedge clk);
    acc_in = 0; rnd_in = 0;
    check("R8", {xt_dout, ms_dout, ls_dout}, model);

    // R9: enables pass through outside preload, forced off inside
    xt_en = 1; ms_en = 1; ls_en = 0;
    #1;
    check("R9", {32'h0, xt_oe, ms_oe, ls_oe}, {32'h0, 3'b110});
    @(negedge clk);
    preload = 1; xt_en = 0; ms_en = 0; ls_en = 0;
    #1;
    check("R9", {32'h0, xt_oe, ms_oe, ls_oe}, 35'h0);

    // R10: preload all fields, p_ce also high and ignored
    @(negedge clk);
    preload = 1; xt_en = 1; ms_en = 1; ls_en = 1; p_ce = 1;
    xt_din = 3'b101; ms_din = 16'hABCD; y_in = 16'h1357;
    @(negedge clk);
    xt_en = 0; ms_en = 0; ls_en = 0; p_ce = 0;
    check("R10", {xt_dout, ms_dout, ls_dout}, {3'b101, 16'hABCD, 16'h1357});
    // R10: only upper field strobed; others hold
    ms_en = 1; ms_din = 16'h0F0F; xt_din = 3'b010; y_in = 16'hFFFF;
    @(negedge clk);
    ms_en = 0; preload = 0;
    check("R10", {xt_dout, ms_dout, ls_dout}, {3'b101, 16'h0F0F, 16'h1357});
    model = {3'b101, 16'h0F0F, 16'h1357};

    // R11: accumulate on top of the preloaded value (add, then signed subtract)
    run_op(4'h4, 16'hF000, 16'h1234);
    check("R11", {xt_dout, ms_dout, ls_dout}, model);
    run_op(4'hE, 16'h8000, 16'h7FFF);
    check("R11", {xt_dout, ms_dout, ls_dout}, model);

    // R1: reset after activity
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1", {xt_dout, ms_dout, ls_dout}, 35'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule